// File: doc/BRIEF.md
# Dual-Priority Interrupt Router

This block gathers a small group of peripheral interrupt request levels and steers each one into one of two latch registers: a high-priority latch or a low-priority latch. A per-source priority-select bit chooses the latch. A per-source enable bit gates each request before the latches. Each latch register ORs down to its own registered summary request toward a processor core. There is one summary line for each priority level.

The latch bits hold the input level and do not record edges. Reading them never clears them. A bit drops only when its source deasserts or is disabled. A plain synchronous address, data and strobe port gives read access to both latches and read/write access to the priority and enable registers. Writes to the two latch offsets are dropped.

Top module: `irq_prio_router`

## Requirements
- R1: With its enable bit at 1, a source whose priority bit is 1 sets its bit in the high latch at the next clock edge, and its bit in the low latch stays 0. With the priority bit at 0, the source sets its bit in the low latch instead, and its bit in the high latch stays 0. Bit i of every register belongs to source i, and there are NSRC sources (10 by default).
- R2: After reset the priority register, the enable register, both latches and both summary outputs are all zero, so every source maps to low priority.
- R3: A source whose enable bit is 0 never sets a bit in either latch, whatever its input level.
- R4: Reading a latch leaves its contents unchanged. A latch bit returns to 0 at the first clock edge at which its source input is low.
- R5: If a source's priority bit changes while its input stays high, its set bit moves from one latch to the other at the next edge after the write takes effect. The bit is never set in both latches in the same cycle.
- R6: `hi_req` equals the OR of the high latch as it was one clock earlier. `lo_req` equals the OR of the low latch as it was one clock earlier.
- R7: Register offsets on `reg_addr`:
  - 0 reads the high latch.
  - 1 reads the low latch.
  - 2 reads and writes the priority register.
  - 3 reads and writes the enable register.

  Data sits in bits NSRC-1:0 of the data bus, and the upper bits read as 0. A write takes effect at the clock edge where `reg_we` is 1. `reg_rdata` reflects `reg_addr` combinationally.
- R8: Writes to offsets 0 and 1 change no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| src_irq | input | NSRC | Interrupt request levels, one per source |
| reg_addr | input | 2 | Register offset |
| reg_we | input | 1 | Write strobe |
| reg_wdata | input | DW | Write data |
| reg_rdata | output | DW | Read data for `reg_addr` |
| hi_req | output | 1 | High-priority summary request |
| lo_req | output | 1 | Low-priority summary request |

## Verification
The bench sweeps every one of the 1024 priority patterns, each paired with an arithmetically derived enable pattern and request pattern. The expected high latch is request AND enable AND priority. The expected low latch is request AND enable AND NOT priority. This separates a wrong steering polarity, a missing enable gate and a wrong bit mapping. The summary outputs are checked against the OR of those expected values in the same sweep.

Directed sequences cover the remaining cases:
- flipping the priority bit while a request is held, sampling the cycle before and the cycle after the move to show the bit moves without ever being set in both latches;
- repeated reads of a latch, to show reading does not clear it;
- deasserting a request, to show the bit clears on the next edge;
- writes to the read-only offsets, to show they are dropped.

// File: rtl/irq_prio_router.sv
module irq_prio_router #(
  parameter int NSRC = 10,
  parameter int DW   = 16
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NSRC-1:0] src_irq,
  input  logic [1:0]      reg_addr,
  input  logic            reg_we,
  input  logic [DW-1:0]   reg_wdata,
  output logic [DW-1:0]   reg_rdata,
  output logic            hi_req,
  output logic            lo_req
);
  localparam int PAD = DW - NSRC;

  logic [NSRC-1:0] hi_lat, lo_lat, pri_q, en_q;
  logic [NSRC-1:0] gated;

  assign gated = src_irq & en_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pri_q <= '0;
      en_q  <= '0;
    end else if (reg_we) begin
      if (reg_addr == 2'd2) pri_q <= reg_wdata[NSRC-1:0];
      if (reg_addr == 2'd3) en_q  <= reg_wdata[NSRC-1:0];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hi_lat <= '0;
      lo_lat <= '0;
      hi_req <= 1'b0;
      lo_req <= 1'b0;
    end else begin
      hi_lat <= gated & pri_q;
      lo_lat <= gated & ~pri_q;
      hi_req <= |hi_lat;
      lo_req <= |lo_lat;
    end
  end

  always_comb begin
    case (reg_addr)
      2'd0:    reg_rdata = {{PAD{1'b0}}, hi_lat};
      2'd1:    reg_rdata = {{PAD{1'b0}}, lo_lat};
      2'd2:    reg_rdata = {{PAD{1'b0}}, pri_q};
      default: reg_rdata = {{PAD{1'b0}}, en_q};
    endcase
  end
endmodule

module irq_prio_router_chk #(
  parameter int NSRC = 10
) (
  input logic            clk,
  input logic            rst_n,
  input logic [NSRC-1:0] src_irq,
  input logic [NSRC-1:0] hi_lat,
  input logic [NSRC-1:0] lo_lat,
  input logic [NSRC-1:0] en_q,
  input logic            hi_req,
  input logic            lo_req
);
  // R5: a source is never set in both latches at once
  p_disjoint_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (hi_lat & lo_lat) == '0);

  // R6: summary outputs follow their latch one cycle later
  p_hi_sum_r6: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (hi_req == $past(|hi_lat)));
  p_lo_sum_r6: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (lo_req == $past(|lo_lat)));

  // R4: a latched bit needs its input high on the previous edge
  p_level_r4: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (((hi_lat | lo_lat) & ~$past(src_irq)) == '0));

  // R3: a disabled source never appears in a latch
  p_gate_r3: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (((hi_lat | lo_lat) & ~$past(en_q)) == '0));
endmodule

bind irq_prio_router irq_prio_router_chk #(.NSRC(NSRC)) u_chk (
  .clk(clk), .rst_n(rst_n), .src_irq(src_irq),
  .hi_lat(hi_lat), .lo_lat(lo_lat), .en_q(en_q),
  .hi_req(hi_req), .lo_req(lo_req)
);

// File: tb/sim_irq_prio_router.sv
`timescale 1ns/1ps
module sim_irq_prio_router;
  localparam int NSRC = 10;
  localparam int DW   = 16;
  localparam int MASK = (1 << NSRC) - 1;

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic [NSRC-1:0] src_irq = '0;
  logic [1:0]      reg_addr = '0;
  logic            reg_we = 1'b0;
  logic [DW-1:0]   reg_wdata = '0;
  logic [DW-1:0]   reg_rdata;
  logic            hi_req, lo_req;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #2.5 clk = ~clk;

  irq_prio_router #(.NSRC(NSRC), .DW(DW)) u0 (
    .clk(clk), .rst_n(rst_n), .src_irq(src_irq), .reg_addr(reg_addr),
    .reg_we(reg_we), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .hi_req(hi_req), .lo_req(lo_req)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic wr(input int a, input int d);
    @(negedge clk);
    reg_addr = a[1:0]; reg_wdata = d[DW-1:0]; reg_we = 1'b1;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic rd(input int a, output int d);
    reg_addr = a[1:0];
    #0.5;
    d = int'(reg_rdata);
  endtask

  initial begin
    int v, h, l;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R2 reset state
    rd(0, v); chk("R2 hi latch", v, 0);
    rd(1, v); chk("R2 lo latch", v, 0);
    rd(2, v); chk("R2 priority", v, 0);
    rd(3, v); chk("R2 enable", v, 0);
    chk("R2 hi_req", int'(hi_req), 0);
    chk("R2 lo_req", int'(lo_req), 0);

    // R3 all inputs high but nothing enabled
    src_irq = NSRC'(MASK);
    repeat (3) @(negedge clk);
    rd(0, v); chk("R3 hi latch disabled", v, 0);
    rd(1, v); chk("R3 lo latch disabled", v, 0);
    chk("R3 lo_req disabled", int'(lo_req), 0);

    // R1/R6/R7 sweep of every priority pattern
    for (int p = 0; p <= MASK; p++) begin
      int e, q, eh, el;
      e = (p * 37 + 5) & MASK;
      q = (p * 91 + 13) & MASK;
      wr(2, p);
      wr(3, e);
      src_irq = NSRC'(q);
      @(negedge clk); @(negedge clk);
      eh = q & e & p;
      el = q & e & ~p & MASK;
      rd(0, h); chk("R1 hi latch sweep", h, eh);
      rd(1, l); chk("R1 lo latch sweep", l, el);
      rd(2, v); chk("R7 priority readback", v, p);
      rd(3, v); chk("R7 enable readback", v, e);
      chk("R6 hi_req sweep", int'(hi_req), int'(eh != 0));
      chk("R6 lo_req sweep", int'(lo_req), int'(el != 0));
    end

    // R5 priority flip while held high
    wr(3, 1); wr(2, 0);
    src_irq = NSRC'(1);
    @(negedge clk); @(negedge clk);
    rd(1, v); chk("R5 lo before flip", v, 1);
    wr(2, 1);
    rd(0, h); rd(1, l);
    chk("R5 hi same cycle as write", h, 0);
    chk("R5 lo same cycle as write", l, 1);
    @(negedge clk);
    rd(0, h); rd(1, l);
    chk("R5 hi after flip", h, 1);
    chk("R5 lo after flip", l, 0);

    // R4 reads do not clear
    for (int k = 0; k < 4; k++) begin
      rd(0, v); @(negedge clk);
    end
    rd(0, v); chk("R4 hi after repeated reads", v, 1);
    src_irq = '0;
    @(negedge clk);
    rd(0, v); chk("R4 hi clears on deassert", v, 0);

    // R8 writes to read-only offsets dropped
    wr(0, MASK); wr(1, MASK);
    rd(0, v); chk("R8 hi after write", v, 0);
    rd(1, v); chk("R8 lo after write", v, 0);
    rd(2, v); chk("R8 priority kept", v, 1);
    rd(3, v); chk("R8 enable kept", v, 1);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule